// File: doc/BRIEF.md
# Programmable Reload Down-Counter Timer

A 16-bit down-counting timer for a small processor peripheral bus. Software programs a start value as two bytes, picks a prescaler ratio, and starts the counter in one of two modes. In single-pass mode the timer runs to its end of count once and then turns itself off. In continuous mode it reloads the start value at every end of count and keeps running until software turns it off.

Each end of count raises a status flag. Software can poll this flag, or it can enable it onto an interrupt request line. Reading the status register returns the flag and clears it. A start value of zero gives the longest period, 65536 prescaled ticks. Loading a zero does not stop the timer and does not raise the flag.

Register map on the byte bus:

| Offset | Register | Contents |
|---|---|---|
| 0 | control | bit0 = run enable, bit1 = load request, bits[3:2] = divider select, bit4 = continuous mode |
| 1 | interrupt enable | bit0 |
| 2 | status | bit0 = end-of-count flag |
| 3 | start value, low byte | |
| 4 | start value, high byte | |
| 5 | live count, low byte (read-only) | |
| 6 | live count, high byte (read-only) | |

Any bit or offset not listed reads as 0.

Top module: `prt_timer`

## Requirements
- R1: After reset, every register reads 0, the live count reads 0 and `irq` is low.
- R2: The start value is {high byte at offset 4, low byte at offset 3}, and both bytes read back as written.
- R3: While the timer is enabled, divider select 00/01/10/11 produces one tick every 4/16/64/256 clocks. The first tick comes that many clocks after the write that sets the enable bit.
- R4: Writing 1 to control bit1 sets a pending load request, which reads back as 1. On the next tick the counter takes the start value and the request clears itself. Writing 0 to bit1 does not cancel a pending request.
- R5: Every other tick decrements the count. The end of count is the tick at which the count is 1. In single-pass mode (bit4 = 0) the count becomes 0 there and the enable bit clears. With a start value R loaded at enable, the end comes (R+1)·D clocks after the enabling write, where D is the divide ratio.
- R6: In continuous mode (bit4 = 1) the end-of-count tick reloads the start value, and the timer stays enabled. Each later end of count follows the previous one by R·D clocks.
- R7: A start value of 0 is loaded as 0000h. The next tick makes the count FFFFh, which gives a 65536-tick period. The load itself never sets the flag.
- R8: The status flag (offset 2, bit0) is set by an end of count and by nothing else. A status read returns the flag and clears it. If an end of count falls on the same cycle as the read, the flag stays set.
- R9: `irq` is high exactly when the status flag is set and interrupt-enable bit0 is 1. With the enable bit at 0, the flag still sets and `irq` stays low.
- R10: Clearing the enable bit stops counting, and the live count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset, synchronous to clk |
| busAddr | input | 3 | Register offset |
| busWrEn | input | 1 | Write strobe, one cycle per byte |
| busRdEn | input | 1 | Read strobe; a read of the status register clears the flag |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for busAddr, combinational |
| irq | output | 1 | Interrupt request |

## Verification
Three kinds of internal fault can be seen from outside:
- **Wrong prescaler phase or divide ratio.** The `irq` edge moves away from the clock cycle the bench predicts, (R+1)·D clocks after the enabling write. The bench checks the cycle before the edge and the edge itself, so a fault of a single clock is caught at the first end of count.
- **Faulty reload path or zero-value handling.** The live-count bytes read the wrong value within one tick of the load. The next continuous period also arrives at the wrong cycle.
- **Flag fault.** A flag raised by a load shows as `irq` high or a status of 1 before any end of count. A flag that fails to clear shows as `irq` still high on the cycle after the status read.

// File: rtl/prt_pkg.sv
package prt_pkg;
  localparam int CNT_W   = 16;
  localparam int NBYTES  = CNT_W / 8;
  localparam int ADDR_W  = 3;
  localparam int PRE_W   = 8;

  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_IE     = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_STAT   = 3'd2;
  localparam int                RELOAD_BASE = 3;
  localparam int                COUNT_BASE  = RELOAD_BASE + NBYTES;

  typedef struct packed {
    logic       run;
    logic [1:0] divSel;
    logic       loadReq;
    logic       contMode;
  } prtStrobe_t;

  typedef struct packed {
    logic loaded;
    logic endOfCount;
  } prtEvent_t;
endpackage

// File: rtl/prt_datapath.sv
module prt_datapath
  import prt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  prtStrobe_t       strobe,
  input  logic [CNT_W-1:0] reloadVal,
  output prtEvent_t        evt,
  output logic [CNT_W-1:0] count
);
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] divLimit;
  logic             tick;
  logic             atOne;

  always_comb begin
    divLimit = PRE_W'((32'd4 << {strobe.divSel, 1'b0}) - 32'd1);
    tick     = strobe.run && (preCnt == divLimit);
    atOne    = (count == CNT_W'(1));
    evt.loaded     = tick && strobe.loadReq;
    evt.endOfCount = tick && !strobe.loadReq && atOne;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                     preCnt <= '0;
    else if (!strobe.run || tick)  preCnt <= '0;
    else                           preCnt <= preCnt + PRE_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (tick) begin
      if (strobe.loadReq)  count <= reloadVal;
      else if (atOne)      count <= strobe.contMode ? reloadVal : '0;
      else                 count <= count - CNT_W'(1);
    end
  end

  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    evt.loaded |=> count == $past(reloadVal)); // R4
  AST_DECREMENT: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !strobe.loadReq && !atOne) |=> count == $past(count) - CNT_W'(1)); // R5
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(count)); // R10
  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> !tick); // R3
endmodule

// File: rtl/prt_control.sv
module prt_control
  import prt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [7:0]        busWrData,
  output logic [7:0]        busRdData,
  output logic              irq,
  input  prtEvent_t         evt,
  input  logic [CNT_W-1:0]  count,
  output prtStrobe_t        strobe,
  output logic [CNT_W-1:0]  reloadVal
);
  logic       enBit, loadPend, contMode, ieBit, eocFlag;
  logic [1:0] divSel;
  logic [7:0] reloadByte [NBYTES];
  logic       ctrlWr, ieWr, statusRd, endEvt;

  assign ctrlWr   = busWrEn && (busAddr == ADDR_CTRL);
  assign ieWr     = busWrEn && (busAddr == ADDR_IE);
  assign statusRd = busRdEn && (busAddr == ADDR_STAT);
  assign endEvt   = evt.endOfCount;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enBit <= 1'b0; loadPend <= 1'b0; divSel <= 2'b00; contMode <= 1'b0;
    end else if (ctrlWr) begin
      enBit    <= busWrData[0];
      loadPend <= (loadPend && !evt.loaded) || busWrData[1];
      divSel   <= busWrData[3:2];
      contMode <= busWrData[4];
    end else begin
      if (endEvt && !contMode) enBit    <= 1'b0;
      if (evt.loaded)          loadPend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)      ieBit <= 1'b0;
    else if (ieWr)  ieBit <= busWrData[0];
  end

  always_ff @(posedge clk) begin
    if (!rstN)         eocFlag <= 1'b0;
    else if (endEvt)   eocFlag <= 1'b1;
    else if (statusRd) eocFlag <= 1'b0;
  end

  for (genvar i = 0; i < NBYTES; i++) begin : g_reload
    always_ff @(posedge clk) begin
      if (!rstN)
        reloadByte[i] <= '0;
      else if (busWrEn && (busAddr == ADDR_W'(RELOAD_BASE + i)))
        reloadByte[i] <= busWrData;
    end
    assign reloadVal[8*i +: 8] = reloadByte[i];
  end

  always_comb begin
    busRdData = 8'h00;
    case (busAddr)
      ADDR_CTRL: busRdData = {3'b000, contMode, divSel, loadPend, enBit};
      ADDR_IE:   busRdData = {7'b0, ieBit};
      ADDR_STAT: busRdData = {7'b0, eocFlag};
      default: begin
        for (int i = 0; i < NBYTES; i++) begin
          if (busAddr == ADDR_W'(RELOAD_BASE + i)) busRdData = reloadByte[i];
          if (busAddr == ADDR_W'(COUNT_BASE + i))  busRdData = count[8*i +: 8];
        end
      end
    endcase
  end

  assign strobe = '{run: enBit, divSel: divSel, loadReq: loadPend, contMode: contMode};
  assign irq    = eocFlag && ieBit;

  AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eocFlag) |-> $past(endEvt)); // R7
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rstN)
    endEvt |=> eocFlag); // R8
  AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (statusRd && !endEvt) |=> !eocFlag); // R8
  AST_SINGLE_STOP: assert property (@(posedge clk) disable iff (!rstN)
    (endEvt && !contMode && !ctrlWr) |=> !enBit); // R5
  AST_CONT_RUN: assert property (@(posedge clk) disable iff (!rstN)
    (endEvt && contMode && !ctrlWr) |=> enBit); // R6
  AST_LOAD_SELFCLR: assert property (@(posedge clk) disable iff (!rstN)
    (evt.loaded && !(ctrlWr && busWrData[1])) |=> !loadPend); // R4
endmodule

// File: rtl/prt_timer.sv
module prt_timer
  import prt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [7:0]        busWrData,
  output logic [7:0]        busRdData,
  output logic              irq
);
  prtStrobe_t       strobe;
  prtEvent_t        evt;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] reloadVal;

  prt_control u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData),
    .irq(irq), .evt(evt), .count(count), .strobe(strobe), .reloadVal(reloadVal)
  );

  prt_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reloadVal(reloadVal),
    .evt(evt), .count(count)
  );

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(evt.endOfCount) || $past(busWrEn && busAddr == ADDR_IE)); // R9
endmodule

// File: tb/prt_timer_test.sv
module prt_timer_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] busAddr = '0;
  logic       busWrEn = 1'b0;
  logic       busRdEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic       irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  localparam logic [2:0] A_CTRL = 3'd0, A_IE = 3'd1, A_STAT = 3'd2,
                         A_RLO = 3'd3, A_RHI = 3'd4, A_CLO = 3'd5, A_CHI = 3'd6;

  prt_timer uut (.clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
                 .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData), .irq(irq));

  always #10 clk = ~clk;

  function automatic int divFactor(int sel);
    return 4 << (2 * sel);
  endfunction
  function automatic int firstEnd(int r, int sel);
    return ((r == 0) ? 65537 : r + 1) * divFactor(sel);
  endfunction
  function automatic int contPeriod(int r, int sel);
    return ((r == 0) ? 65536 : r) * divFactor(sel);
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitNeg(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeReg(logic [2:0] a, logic [7:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic readReg(logic [2:0] a, output logic [7:0] d);
    busAddr = a; busRdEn = 1'b1;
    #1 d = busRdData;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic setup(int r, int ie);
    logic [7:0] junk;
    writeReg(A_CTRL, 8'h00);
    readReg(A_STAT, junk);
    writeReg(A_RLO, 8'(r));
    writeReg(A_RHI, 8'(r >> 8));
    writeReg(A_IE, 8'(ie));
  endtask

  task automatic runSingle(int r, int sel, int ie);
    logic [7:0] d;
    int n;
    setup(r, ie);
    writeReg(A_CTRL, 8'((sel << 2) | 3));
    n = firstEnd(r, sel);
    waitNeg(n - 1);
    check("R3 irq low before end", int'(irq), 0);
    waitNeg(1);
    check("R5/R9 irq at end of count", int'(irq), ie);
    readReg(A_STAT, d);
    check("R8 status flag set", int'(d), 1);
    check("R8 irq cleared by status read", int'(irq), 0);
    readReg(A_CTRL, d);
    check("R5 enable cleared after single pass", int'(d), sel << 2);
    readReg(A_CLO, d);
    check("R5 count zero after single pass", int'(d), 0);
  endtask

  task automatic runCont(int r, int sel);
    logic [7:0] d;
    int n;
    setup(r, 1);
    writeReg(A_CTRL, 8'(16 | (sel << 2) | 3));
    n = firstEnd(r, sel);
    waitNeg(n - 1);
    check("R6 irq low before first end", int'(irq), 0);
    waitNeg(1);
    check("R6 irq at first end", int'(irq), 1);
    readReg(A_STAT, d);
    check("R8 status read in continuous", int'(d), 1);
    waitNeg(contPeriod(r, sel) - 2);
    check("R6 irq low before second end", int'(irq), 0);
    waitNeg(1);
    check("R6 irq at second end", int'(irq), 1);
    readReg(A_CTRL, d);
    check("R6 still enabled", int'(d), 16 | (sel << 2) | 1);
    writeReg(A_CTRL, 8'h00);
  endtask

  initial begin
    logic [7:0] d;
    int r, sel, junk;
    junk = int'($urandom(32'd4711));
    waitNeg(3);
    rstN = 1'b1;
    waitNeg(1);

    check("R1 irq after reset", int'(irq), 0);
    readReg(A_CTRL, d); check("R1 control reset", int'(d), 0);
    readReg(A_STAT, d); check("R1 status reset", int'(d), 0);
    readReg(A_CLO, d);  check("R1 count reset", int'(d), 0);

    writeReg(A_RLO, 8'h5A); writeReg(A_RHI, 8'hC3);
    readReg(A_RLO, d); check("R2 reload low readback", int'(d), 8'h5A);
    readReg(A_RHI, d); check("R2 reload high readback", int'(d), 8'hC3);

    runSingle(3, 0, 1);
    runSingle(2, 3, 1);
    runSingle(5, 1, 0);
    for (int t = 0; t < 6; t++) begin
      r = 1 + int'($urandom % 40);
      sel = int'($urandom % 3);
      runSingle(r, sel, 1);
    end
    runCont(1, 0);
    for (int t = 0; t < 4; t++) begin
      r = 1 + int'($urandom % 30);
      sel = int'($urandom % 3);
      runCont(r, sel);
    end

    // R7: zero start value
    setup(0, 1);
    writeReg(A_CTRL, 8'h13);
    waitNeg(4);
    check("R7 no irq on zero load", int'(irq), 0);
    readReg(A_CLO, d); check("R7 zero loaded low", int'(d), 0);
    readReg(A_CHI, d); check("R7 zero loaded high", int'(d), 0);
    waitNeg(2);
    readReg(A_CHI, d); check("R7 wrap high", int'(d), 8'hFF);
    readReg(A_CLO, d); check("R7 wrap low", int'(d), 8'hFF);
    readReg(A_STAT, d); check("R7 flag not set by zero load", int'(d), 0);

    // R10: disable holds count
    setup(50, 1);
    writeReg(A_CTRL, 8'h03);
    waitNeg(21);
    writeReg(A_CTRL, 8'h00);
    waitNeg(30);
    readReg(A_CLO, d); check("R10 count held low", int'(d), 50 - ((22 - 1) / 4 - 1));
    readReg(A_CHI, d); check("R10 count held high", int'(d), 0);
    check("R10 no irq while stopped", int'(irq), 0);

    // R4: pending load request
    writeReg(A_CTRL, 8'h02);
    readReg(A_CTRL, d); check("R4 pending while disabled", int'(d), 2);
    writeReg(A_CTRL, 8'h01);
    readReg(A_CTRL, d); check("R4 pending survives write of 0", int'(d), 3);
    waitNeg(3);
    readReg(A_CTRL, d); check("R4 request self-clears", int'(d), 1);
    readReg(A_CLO, d); check("R4 counter took start value", int'(d), 50);
    writeReg(A_CTRL, 8'h00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule